// File: doc/BRIEF.md
# MDIO PHY Scan and Arbitration Engine

This block keeps a live picture of every PHY on a management bus while leaving the bus available to software. Whenever it is enabled, it walks through all PHY addresses in a fixed round-robin order. At each address it reads the basic status register. It records two things per address: whether the PHY answered, and whether it reports link up. Each time a PHY's link state changes, the block sets a sticky interrupt flag for that PHY.

The serial frame engine itself sits outside this block and is reached through a simple request/done handshake. Software accesses share that engine with the background scan. A software request is granted at the next frame boundary, so it never waits behind more than one scan frame.

Clearing the enable is an orderly stop. No new frame is started, and the frame already in flight is allowed to complete. After that the idle flag rises. Setting the enable again resumes work. A held software request is served first, and scanning then continues from the address after the last one scanned.

Top module: `mdio_scan_arb`

## Requirements
- R1: Synchronous reset (`rst` high) clears these outputs to zero: `alive`, `link`, `link_raw`, `uirq_raw`, the user-interrupt mask, `fe_req` and `usr_busy`. It sets `idle` to 1.
- R2: While enabled and with no user request pending, the block issues read frames (`fe_wr`=0) of register 1 (`fe_reg`=1). It sends them to PHY addresses 0, 1, …, 31 and then wraps to 0. The first frame after reset goes to address 0.
- R3: When a scan frame completes (`fe_done`=1), the block updates the bits for that PHY address on the same clock edge. `alive[a]` takes the value of `fe_ack`, and `link[a]` takes `fe_ack` AND `fe_rdata[2]`. A PHY that does not acknowledge therefore has both bits cleared.
- R4: Any change of `link[a]` sets `link_raw[a]`. Each bit of `link_raw` stays set until a cycle in which the matching bit of `link_raw_clr` is 1; bits written 0 are left unchanged. `link_masked` equals `link_raw` AND `link_mask`.
- R5: A `usr_go` pulse while `usr_busy`=0 captures `usr_wr`, `usr_phy`, `usr_reg` and `usr_wdata`, and raises `usr_busy` on the next edge. The captured fields are then sent as one frame. On the edge that samples its `fe_done`, the block does three things. It pulses `usr_done` for one cycle, it drops `usr_busy`, and it presents `fe_ack` and `fe_rdata` on `usr_ack` and `usr_rdata`.
- R6: A user request is issued with at most one scan frame started after the `usr_go` pulse. The scan frame that follows the user frame goes to the address after the last scanned address.
- R7: `uirq_raw` is set on the same edge as `usr_done`. It stays set until a cycle with `uirq_clr`=1. The mask bit is set by `uirq_mset`=1 and cleared by `uirq_mclr`=1. `uirq_masked` equals `uirq_raw` AND the mask.
- R8: While `enable`=1, `idle` is 0. With `enable`=0 no new frame is started and a frame in flight runs to completion. `idle` then rises on the edge that samples that frame's `fe_done`, or one edge after `enable` falls if no frame is in flight. A user request made while disabled stays pending.
- R9: When `enable` returns to 1, a pending user request is issued first. Scanning then resumes at the address after the last scanned one.
- R10: `fe_req` stays high with `fe_wr`, `fe_phy`, `fe_reg` and `fe_wdata` stable until `fe_done` is seen. It drops on that edge.
- R11: A `usr_go` pulse while `usr_busy`=1 is ignored. Only the first request is sent, with its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scan and access enable |
| idle | output | 1 | No activity and disabled |
| usr_go | input | 1 | Start a user access (pulse) |
| usr_wr | input | 1 | 1 = write, 0 = read |
| usr_phy | input | 5 | User target PHY address |
| usr_reg | input | 5 | User target register |
| usr_wdata | input | 16 | User write data |
| usr_busy | output | 1 | User access pending or in flight |
| usr_done | output | 1 | One-cycle completion pulse |
| usr_ack | output | 1 | PHY acknowledged the user access |
| usr_rdata | output | 16 | Data returned by the user access |
| fe_req | output | 1 | Frame request to the serial engine |
| fe_wr | output | 1 | Frame direction |
| fe_phy | output | 5 | Frame PHY address |
| fe_reg | output | 5 | Frame register address |
| fe_wdata | output | 16 | Frame write data |
| fe_done | input | 1 | Frame finished (one cycle) |
| fe_ack | input | 1 | PHY acknowledged the frame |
| fe_rdata | input | 16 | Frame read data |
| alive | output | 32 | Per-PHY responded bitmap |
| link | output | 32 | Per-PHY link-up bitmap |
| link_mask | input | 32 | Link-interrupt enable per PHY |
| link_raw_clr | input | 32 | Write-1-to-clear for link_raw |
| link_raw | output | 32 | Sticky link-change flags |
| link_masked | output | 32 | link_raw AND link_mask |
| uirq_clr | input | 1 | Clear user-interrupt raw bit |
| uirq_mset | input | 1 | Set user-interrupt mask |
| uirq_mclr | input | 1 | Clear user-interrupt mask |
| uirq_raw | output | 1 | User-access completion flag |
| uirq_masked | output | 1 | uirq_raw AND mask |

## Verification
Three groups of results appear on the edge that samples `fe_done`: the bitmaps and link flags, the user result with its interrupt bit, and the drop of `fe_req` together with `idle`. A new frame request follows one edge after the block returns to free, and clear and mask writes act on the next edge. The bench therefore drives inputs and samples outputs on falling edges, one half-period after the edge that carries each effect. The PHY model answers a fixed number of cycles after it sees a request and logs every frame it receives. Ordering and the one-frame arbitration bound are judged from that log, counted in frames rather than in absolute cycles.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;
  localparam int PHY_AW  = 5;
  localparam int REG_AW  = 5;
  localparam int FRAME_W = 16;

  typedef enum logic {ARB_FREE, ARB_BUSY} arb_state_e;
  typedef enum logic {OWN_SCAN, OWN_USER} arb_owner_e;
endpackage

// File: rtl/msa_user_port.sv
module msa_user_port #(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usr_go,
  input  logic              usr_wr,
  input  logic [PHY_W-1:0]  usr_phy,
  input  logic [REG_W-1:0]  usr_reg,
  input  logic [DATA_W-1:0] usr_wdata,
  input  logic              usr_cmp,
  input  logic              fe_ack,
  input  logic [DATA_W-1:0] fe_rdata,
  input  logic              uirq_clr,
  input  logic              uirq_mset,
  input  logic              uirq_mclr,
  output logic              pend,
  output logic              pend_wr,
  output logic [PHY_W-1:0]  pend_phy,
  output logic [REG_W-1:0]  pend_reg,
  output logic [DATA_W-1:0] pend_wdata,
  output logic              usr_done,
  output logic              usr_ack,
  output logic [DATA_W-1:0] usr_rdata,
  output logic              uirq_raw,
  output logic              uirq_masked
);
  logic uirq_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      pend_wr    <= 1'b0;
      pend_phy   <= '0;
      pend_reg   <= '0;
      pend_wdata <= '0;
      usr_done   <= 1'b0;
      usr_ack    <= 1'b0;
      usr_rdata  <= '0;
    end else begin
      usr_done <= 1'b0;
      if (usr_cmp) begin
        pend      <= 1'b0;
        usr_done  <= 1'b1;
        usr_ack   <= fe_ack;
        usr_rdata <= fe_rdata;
      end else if (usr_go && !pend) begin
        pend       <= 1'b1;
        pend_wr    <= usr_wr;
        pend_phy   <= usr_phy;
        pend_reg   <= usr_reg;
        pend_wdata <= usr_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uirq_raw  <= 1'b0;
      uirq_mask <= 1'b0;
    end else begin
      if (usr_cmp)       uirq_raw <= 1'b1;
      else if (uirq_clr) uirq_raw <= 1'b0;
      if (uirq_mset)      uirq_mask <= 1'b1;
      else if (uirq_mclr) uirq_mask <= 1'b0;
    end
  end

  assign uirq_masked = uirq_raw & uirq_mask;
endmodule

// File: rtl/msa_arbiter.sv
module msa_arbiter
  import mdio_scan_pkg::*;
#(
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int STAT_REG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              usr_pend,
  input  logic              usr_wr,
  input  logic [PHY_W-1:0]  usr_phy,
  input  logic [REG_W-1:0]  usr_reg,
  input  logic [DATA_W-1:0] usr_wdata,
  input  logic              fe_done,
  output logic              fe_req,
  output logic              fe_wr,
  output logic [PHY_W-1:0]  fe_phy,
  output logic [REG_W-1:0]  fe_reg,
  output logic [DATA_W-1:0] fe_wdata,
  output logic              scan_cmp,
  output logic              usr_cmp,
  output logic              idle
);
  localparam logic [REG_W-1:0] SCAN_REG = REG_W'(STAT_REG);

  arb_state_e        st;
  arb_owner_e        own;
  logic [PHY_W-1:0]  scan_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ARB_FREE;
      own       <= OWN_SCAN;
      fe_req    <= 1'b0;
      fe_wr     <= 1'b0;
      fe_phy    <= '0;
      fe_reg    <= '0;
      fe_wdata  <= '0;
      scan_addr <= '0;
      idle      <= 1'b1;
    end else begin
      case (st)
        ARB_FREE: begin
          idle <= !enable;
          if (enable && usr_pend) begin
            st       <= ARB_BUSY;
            own      <= OWN_USER;
            fe_req   <= 1'b1;
            fe_wr    <= usr_wr;
            fe_phy   <= usr_phy;
            fe_reg   <= usr_reg;
            fe_wdata <= usr_wdata;
          end else if (enable) begin
            st        <= ARB_BUSY;
            own       <= OWN_SCAN;
            fe_req    <= 1'b1;
            fe_wr     <= 1'b0;
            fe_phy    <= scan_addr;
            fe_reg    <= SCAN_REG;
            fe_wdata  <= '0;
            scan_addr <= scan_addr + PHY_W'(1);
          end
        end
        default: begin
          if (fe_done) begin
            st     <= ARB_FREE;
            fe_req <= 1'b0;
            idle   <= !enable;
          end else begin
            idle <= 1'b0;
          end
        end
      endcase
    end
  end

  assign scan_cmp = (st == ARB_BUSY) && (own == OWN_SCAN) && fe_done;
  assign usr_cmp  = (st == ARB_BUSY) && (own == OWN_USER) && fe_done;
endmodule

// File: rtl/msa_status.sv
module msa_status #(
  parameter int PHY_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scan_cmp,
  input  logic [PHY_W-1:0]        scan_phy,
  input  logic                    fe_ack,
  input  logic                    link_bit,
  input  logic [(1<<PHY_W)-1:0]   link_mask,
  input  logic [(1<<PHY_W)-1:0]   link_raw_clr,
  output logic [(1<<PHY_W)-1:0]   alive,
  output logic [(1<<PHY_W)-1:0]   link,
  output logic [(1<<PHY_W)-1:0]   link_raw,
  output logic [(1<<PHY_W)-1:0]   link_masked
);
  localparam int NPHY = 1 << PHY_W;

  logic new_link;
  assign new_link = fe_ack & link_bit;

  for (genvar g = 0; g < NPHY; g++) begin : g_phy
    localparam logic [PHY_W-1:0] IDX = PHY_W'(g);
    logic hit;
    assign hit = scan_cmp && (scan_phy == IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        alive[g]    <= 1'b0;
        link[g]     <= 1'b0;
        link_raw[g] <= 1'b0;
      end else begin
        if (hit) begin
          alive[g] <= fe_ack;
          link[g]  <= new_link;
        end
        if (hit && (new_link != link[g])) link_raw[g] <= 1'b1;
        else if (link_raw_clr[g])         link_raw[g] <= 1'b0;
      end
    end
  end

  assign link_masked = link_raw & link_mask;
endmodule

// File: rtl/mdio_scan_arb.sv
module mdio_scan_arb
  import mdio_scan_pkg::*;
#(
  parameter int PHY_W    = PHY_AW,
  parameter int REG_W    = REG_AW,
  parameter int DATA_W   = FRAME_W,
  parameter int STAT_REG = 1,
  parameter int LINK_BIT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  output logic                  idle,
  input  logic                  usr_go,
  input  logic                  usr_wr,
  input  logic [PHY_W-1:0]      usr_phy,
  input  logic [REG_W-1:0]      usr_reg,
  input  logic [DATA_W-1:0]     usr_wdata,
  output logic                  usr_busy,
  output logic                  usr_done,
  output logic                  usr_ack,
  output logic [DATA_W-1:0]     usr_rdata,
  output logic                  fe_req,
  output logic                  fe_wr,
  output logic [PHY_W-1:0]      fe_phy,
  output logic [REG_W-1:0]      fe_reg,
  output logic [DATA_W-1:0]     fe_wdata,
  input  logic                  fe_done,
  input  logic                  fe_ack,
  input  logic [DATA_W-1:0]     fe_rdata,
  output logic [(1<<PHY_W)-1:0] alive,
  output logic [(1<<PHY_W)-1:0] link,
  input  logic [(1<<PHY_W)-1:0] link_mask,
  input  logic [(1<<PHY_W)-1:0] link_raw_clr,
  output logic [(1<<PHY_W)-1:0] link_raw,
  output logic [(1<<PHY_W)-1:0] link_masked,
  input  logic                  uirq_clr,
  input  logic                  uirq_mset,
  input  logic                  uirq_mclr,
  output logic                  uirq_raw,
  output logic                  uirq_masked
);
  logic              pend, pend_wr;
  logic [PHY_W-1:0]  pend_phy;
  logic [REG_W-1:0]  pend_reg;
  logic [DATA_W-1:0] pend_wdata;
  logic              scan_cmp, usr_cmp;

  msa_user_port #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_user (
    .clk(clk), .rst(rst),
    .usr_go(usr_go), .usr_wr(usr_wr), .usr_phy(usr_phy), .usr_reg(usr_reg),
    .usr_wdata(usr_wdata), .usr_cmp(usr_cmp), .fe_ack(fe_ack), .fe_rdata(fe_rdata),
    .uirq_clr(uirq_clr), .uirq_mset(uirq_mset), .uirq_mclr(uirq_mclr),
    .pend(pend), .pend_wr(pend_wr), .pend_phy(pend_phy), .pend_reg(pend_reg),
    .pend_wdata(pend_wdata), .usr_done(usr_done), .usr_ack(usr_ack),
    .usr_rdata(usr_rdata), .uirq_raw(uirq_raw), .uirq_masked(uirq_masked)
  );

  msa_arbiter #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W), .STAT_REG(STAT_REG)) u_arb (
    .clk(clk), .rst(rst), .enable(enable),
    .usr_pend(pend), .usr_wr(pend_wr), .usr_phy(pend_phy), .usr_reg(pend_reg),
    .usr_wdata(pend_wdata), .fe_done(fe_done),
    .fe_req(fe_req), .fe_wr(fe_wr), .fe_phy(fe_phy), .fe_reg(fe_reg),
    .fe_wdata(fe_wdata), .scan_cmp(scan_cmp), .usr_cmp(usr_cmp), .idle(idle)
  );

  msa_status #(.PHY_W(PHY_W)) u_stat (
    .clk(clk), .rst(rst), .scan_cmp(scan_cmp), .scan_phy(fe_phy),
    .fe_ack(fe_ack), .link_bit(fe_rdata[LINK_BIT]),
    .link_mask(link_mask), .link_raw_clr(link_raw_clr),
    .alive(alive), .link(link), .link_raw(link_raw), .link_masked(link_masked)
  );

  assign usr_busy = pend;
endmodule

// File: rtl/mdio_scan_arb_chk.sv
module mdio_scan_arb_chk #(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  enable,
  input logic                  idle,
  input logic                  usr_go,
  input logic                  usr_busy,
  input logic                  usr_done,
  input logic                  fe_req,
  input logic                  fe_wr,
  input logic [PHY_W-1:0]      fe_phy,
  input logic [REG_W-1:0]      fe_reg,
  input logic [DATA_W-1:0]     fe_wdata,
  input logic                  fe_done,
  input logic [(1<<PHY_W)-1:0] alive,
  input logic [(1<<PHY_W)-1:0] link,
  input logic                  uirq_raw
);
  // R10
  fe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fe_req && !fe_done |=> fe_req && $stable(fe_phy) && $stable(fe_reg)
                           && $stable(fe_wr) && $stable(fe_wdata));
  // R10
  fe_drop_chk: assert property (@(posedge clk) disable iff (rst)
    fe_req && fe_done |=> !fe_req);
  // R3
  link_alive_chk: assert property (@(posedge clk) disable iff (rst)
    (link & ~alive) == '0);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    idle |-> !fe_req);
  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !enable && idle |=> !fe_req);
  // R5
  go_busy_chk: assert property (@(posedge clk) disable iff (rst)
    usr_go && !usr_busy |=> usr_busy);
  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    usr_done |-> !usr_busy);
  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    usr_done |-> uirq_raw);
endmodule

bind mdio_scan_arb mdio_scan_arb_chk #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .idle(idle), .usr_go(usr_go),
  .usr_busy(usr_busy), .usr_done(usr_done), .fe_req(fe_req), .fe_wr(fe_wr),
  .fe_phy(fe_phy), .fe_reg(fe_reg), .fe_wdata(fe_wdata), .fe_done(fe_done),
  .alive(alive), .link(link), .uirq_raw(uirq_raw)
);

// File: tb/tb_mdio_scan_arb.sv
`timescale 1ns/1ps
module tb_mdio_scan_arb;
  localparam int LAT   = 4;
  localparam int LOGSZ = 2048;
  localparam int NV    = 6;
  // {wr, phy, reg, wdata}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 5'd4,  5'd2,  16'h0000},
    {1'b0, 5'd7,  5'd3,  16'h0000},
    {1'b1, 5'd9,  5'd0,  16'hBEEF},
    {1'b0, 5'd31, 5'd31, 16'h0000},
    {1'b1, 5'd1,  5'd4,  16'h1234},
    {1'b0, 5'd12, 5'd17, 16'h0000}
  };

  logic clk = 0, rst = 1, enable = 0;
  logic usr_go = 0, usr_wr = 0;
  logic [4:0] usr_phy = 0, usr_reg = 0;
  logic [15:0] usr_wdata = 0;
  logic fe_done = 0, fe_ack = 0;
  logic [15:0] fe_rdata = 0;
  logic [31:0] link_mask = 32'h0000_FFFF, link_raw_clr = 0;
  logic uirq_clr = 0, uirq_mset = 0, uirq_mclr = 0;
  logic idle, usr_busy, usr_done, usr_ack, fe_req, fe_wr, uirq_raw, uirq_masked;
  logic [15:0] usr_rdata, fe_wdata;
  logic [4:0] fe_phy, fe_reg;
  logic [31:0] alive, link, link_raw, link_masked;

  mdio_scan_arb dut (.*);

  always #4 clk = ~clk;

  logic [31:0] present = 32'hC000_1235;
  logic [31:0] linkup  = 32'h4000_0225;
  logic [4:0]  log_phy [LOGSZ];
  logic [4:0]  log_reg [LOGSZ];
  logic        log_wr  [LOGSZ];
  logic [15:0] log_wd  [LOGSZ];
  int log_n = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [15:0] exp_rd(input logic [4:0] p, input logic [4:0] r);
    if (r == 5'd1) return {13'd0, linkup[p], 2'b00};
    return {1'b1, p, r, 5'd0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY / frame engine model, drives away from the clock edge
  initial begin
    int cnt = 0;
    bit sent = 0;
    forever begin
      @(posedge clk); #2;
      fe_done = 0;
      if (!fe_req) begin
        cnt = 0; sent = 0;
      end else if (!sent) begin
        if (cnt == 0 && log_n < LOGSZ) begin
          log_phy[log_n] = fe_phy; log_reg[log_n] = fe_reg;
          log_wr[log_n] = fe_wr;   log_wd[log_n] = fe_wdata;
          log_n++;
        end
        cnt++;
        if (cnt == LAT) begin
          fe_done = 1;
          fe_ack = present[fe_phy];
          fe_rdata = exp_rd(fe_phy, fe_reg);
          sent = 1;
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_log(input int n);
    while (log_n < n) @(negedge clk);
  endtask

  task automatic do_user(input logic wr, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] wd, output int n_go);
    @(negedge clk);
    usr_wr = wr; usr_phy = p; usr_reg = r; usr_wdata = wd; usr_go = 1;
    n_go = log_n;
    @(negedge clk);
    usr_go = 0;
    chk(usr_busy === 1'b1, "R5 busy after go", usr_busy, 1);
    do @(negedge clk); while (!usr_done);
  endtask

  initial begin
    int n0, idx, bad;
    logic [31:0] exp_l, exp_raw;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(alive === 0 && link === 0, "R1 bitmaps", alive ^ link, 0);
    chk(link_raw === 0 && uirq_raw === 0 && uirq_masked === 0, "R1 flags", {link_raw[30:0], uirq_raw}, 0);
    chk(idle === 1 && fe_req === 0 && usr_busy === 0, "R1 ctrl", {idle, fe_req, usr_busy}, 3'b100);

    enable = 1;
    @(negedge clk); @(negedge clk);
    chk(idle === 0, "R8 idle low when enabled", idle, 0);
    wait_log(66);
    bad = -1;
    for (int k = 0; k < 64; k++)
      if (bad < 0 && (log_phy[k] != k[4:0] || log_reg[k] != 5'd1 || log_wr[k] != 0)) bad = k;
    chk(bad == -1, "R2 scan order", bad, 32'hFFFF_FFFF);
    chk(alive === present, "R3 alive", alive, present);
    chk(link === (present & linkup), "R3 link", link, present & linkup);
    chk(link_raw === (present & linkup), "R4 raw from first sweep", link_raw, present & linkup);
    chk(link_masked === (present & linkup & link_mask), "R4 masked", link_masked, present & linkup & link_mask);

    // R4 write-1 clear
    @(negedge clk); link_raw_clr = 32'h0000_00FF;
    @(negedge clk); link_raw_clr = 0;
    exp_raw = present & linkup & ~32'h0000_00FF;
    chk(link_raw === exp_raw, "R4 clear", link_raw, exp_raw);

    // R3/R4 link changes: phy 4 link up, phy 0 disappears
    linkup[4] = 1'b1; present[0] = 1'b0;
    n0 = log_n;
    wait_log(n0 + 34);
    exp_l = present & linkup;
    chk(alive === present, "R3 alive after change", alive, present);
    chk(link === exp_l, "R3 link after change", link, exp_l);
    exp_raw = exp_raw | 32'h0000_0011;
    chk(link_raw === exp_raw, "R4 raw after change", link_raw, exp_raw);

    // table of user accesses: R5, R6
    for (int v = 0; v < NV; v++) begin
      logic [26:0] e = VEC[v];
      repeat (v * 3) @(negedge clk);
      do_user(e[26], e[25:21], e[20:16], e[15:0], n0);
      chk(usr_busy === 0, "R5 busy released", usr_busy, 0);
      chk(usr_ack === present[e[25:21]], "R5 ack", usr_ack, present[e[25:21]]);
      if (!e[26] && present[e[25:21]])
        chk(usr_rdata === exp_rd(e[25:21], e[20:16]), "R5 rdata", usr_rdata, exp_rd(e[25:21], e[20:16]));
      chk(uirq_raw === 1, "R7 raw at done", uirq_raw, 1);
      repeat (8) @(negedge clk);
      idx = -1;
      for (int k = n0; k < log_n; k++)
        if (idx < 0 && (log_wr[k] || log_reg[k] != 5'd1)) idx = k;
      chk(idx >= 0 && idx <= n0 + 1, "R6 bound", idx - n0, 1);
      if (idx > 0 && idx + 1 < log_n) begin
        chk({log_wr[idx], log_phy[idx], log_reg[idx]} === e[26:16] &&
            (!e[26] || log_wd[idx] === e[15:0]), "R5 frame fields",
            {log_wr[idx], log_phy[idx], log_reg[idx]}, e[26:16]);
        chk(log_phy[idx+1] === log_phy[idx-1] + 5'd1 && log_reg[idx+1] === 5'd1,
            "R6 resume", log_phy[idx+1], log_phy[idx-1] + 5'd1);
      end
    end

    // R7 mask and clear
    chk(uirq_masked === 0, "R7 masked off", uirq_masked, 0);
    @(negedge clk); uirq_mset = 1; @(negedge clk); uirq_mset = 0;
    chk(uirq_masked === 1, "R7 mask set", uirq_masked, 1);
    @(negedge clk); uirq_clr = 1; @(negedge clk); uirq_clr = 0;
    chk(uirq_raw === 0 && uirq_masked === 0, "R7 clear", {uirq_raw, uirq_masked}, 0);
    do_user(1'b0, 5'd2, 5'd5, 16'h0, n0);
    chk(uirq_masked === 1, "R7 masked on done", uirq_masked, 1);
    @(negedge clk); uirq_mclr = 1; @(negedge clk); uirq_mclr = 0;
    chk(uirq_masked === 0 && uirq_raw === 1, "R7 mask clear", {uirq_raw, uirq_masked}, 2'b10);

    // R8 orderly stop
    while (!fe_req) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk(idle === 0, "R8 busy frame not idle", idle, 0);
    while (fe_req) @(negedge clk);
    chk(idle === 1, "R8 idle after done", idle, 1);
    n0 = log_n;
    // R11 second go while busy, held request while disabled
    @(negedge clk);
    usr_wr = 0; usr_phy = 5'd5; usr_reg = 5'd6; usr_go = 1;
    @(negedge clk);
    usr_phy = 5'd9; usr_reg = 5'd7;
    @(negedge clk); usr_go = 0;
    repeat (40) @(negedge clk);
    chk(log_n == n0 && fe_req === 0, "R8 no frame while disabled", log_n - n0, 0);
    chk(usr_busy === 1 && idle === 1, "R8 request held", {usr_busy, idle}, 2'b11);

    // R9 restart
    enable = 1;
    do @(negedge clk); while (!usr_done);
    repeat (30) @(negedge clk);
    chk(log_phy[n0] === 5'd5 && log_reg[n0] === 5'd6, "R9 user first / R11 fields",
        {log_phy[n0], log_reg[n0]}, {5'd5, 5'd6});
    chk(log_phy[n0+1] === log_phy[n0-1] + 5'd1 && log_reg[n0+1] === 5'd1, "R9 scan resume",
        log_phy[n0+1], log_phy[n0-1] + 5'd1);
    bad = 0;
    for (int k = n0; k < log_n; k++) if (log_reg[k] != 5'd1) bad++;
    chk(bad == 1 && usr_busy === 0, "R11 single user frame", bad, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule